// File: doc/BRIEF.md
# MODBUS RTU Frame Receiver Channel

This block is one serial receive channel that collects MODBUS RTU frames with no help from a processor. It deserializes 8N1 characters from the logic-level receive line of a line transceiver and writes each byte into a local frame buffer. It finds the end of a frame by measuring line silence. It checks the two trailing bytes against a CRC-16 that it builds while the bytes arrive. When a frame completes, or when an armed channel gets no answer in time, it raises an interrupt. The outcome is held in a status word.

A host reaches the channel through a simple word-wide register port. Each channel owns a 256-word window, and the address bits above bit 7 select that window. Words 0..127 return the buffered bytes two at a time. Word 128 holds the status code, and writing it forces or clears the error code. Word 129 holds the byte count of the last frame. The host sees only whole frames and their verdict, never single bytes.

Top module: `mbrx_channel`

## Requirements
- R1: Characters are 1 start bit, 8 data bits sent LSB first and 1 stop bit, each bit lasting `bit_div` clocks. After a frame, read word k (k < 128) returns byte 2k in bits 7:0 and byte 2k+1 in bits 15:8, in arrival order starting from byte 0.
- R2: A frame ends once the line has been idle for 3.5 character times, where one character is 10 bits, so the limit is 35*`bit_div` clocks. Gaps between bytes shorter than this keep the bytes in one frame.
- R3: A frame of at least 4 bytes whose last two bytes, low byte first, equal the CRC-16 of all earlier bytes gives status code 1 (done). The CRC uses reflected polynomial 0xA001 and initial value 0xFFFF. Word 129 then reads the byte count.
- R4: A frame whose trailing two bytes differ from the computed CRC gives status code 3 (error).
- R5: A frame of fewer than 4 bytes gives status code 3. A 4-byte frame with a correct CRC gives code 1.
- R6: A frame of more than DEPTH (256) bytes gives status code 3. Bytes beyond DEPTH are dropped, and word 129 reads DEPTH.
- R7: A byte whose stop bit is sampled low makes the whole frame report status code 3.
- R8: After a one-cycle pulse on `arm`, if no start bit is seen within `resp_ticks` clocks, the status becomes code 2 (timeout) and the interrupt is raised. A start bit that arrives earlier cancels the timeout.
- R9: `irq` rises on every frame completion and every timeout. It stays high until the host reads word 128. If a new completion and a status read fall in the same cycle, the interrupt stays set.
- R10: Writing the value 1 to word 128 sets status code 3. Writing 0 sets code 0. Any other value has no effect, and `irq` is not changed by these writes.
- R11: Only accesses whose address bits above bit 7 equal CHAN_ID reach the channel. Writes to other windows are ignored, and reads of other windows return 0.
- R12: After reset the status is 0, `irq` is 0 and `bus_rdata` is 0. Read data appears on `bus_rdata` the cycle after `bus_rd` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial receive line, idle high |
| bit_div | input | DIV_W | Clocks per serial bit |
| resp_ticks | input | RESP_W | Response window in clocks after arming |
| arm | input | 1 | One-cycle pulse that starts the response window |
| bus_addr | input | CH_W+8 | Word address: channel index above bit 7, word offset below |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Interrupt request, held until status is read |

## Verification
The collision of interest is a host status read that lands in the same cycle as the frame completion that raises the interrupt. The bench provokes it by holding `bus_rd` on the status word every cycle while a good frame's end-of-frame silence runs out. Because of that, one read is certain to coincide with the setting edge. The bench judges the outcome at the ports: `irq` must be seen high for at least one cycle, a later read must return the done code, and `irq` must be low after that read.

// File: rtl/mbrx_pkg.sv
package mbrx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_GET_DATA,
        RX_TIMEOUT,
        RX_GET_BYTE,
        RX_FRAME_DONE
    } rx_state_e;

    typedef enum logic [1:0] {
        ST_NONE    = 2'd0,
        ST_DONE    = 2'd1,
        ST_TIMEOUT = 2'd2,
        ST_ERROR   = 2'd3
    } status_e;

    typedef enum logic [1:0] {
        U_IDLE,
        U_START,
        U_DATA,
        U_STOP
    } uart_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       frame_err;
    } rx_byte_t;

    localparam int WIN_BITS   = 8;
    localparam int OFS_STATUS = 128;
    localparam int OFS_LENGTH = 129;
    localparam int MIN_FRAME  = 4;

    function automatic logic [15:0] crc16_step(input logic [15:0] crc_in,
                                               input logic [7:0]  din);
        logic [15:0] c;
        c = crc_in ^ {8'h00, din};
        for (int i = 0; i < 8; i++) begin
            if (c[0]) c = (c >> 1) ^ 16'hA001;
            else      c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/mbrx_uart_rx.sv
module mbrx_uart_rx
    import mbrx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rxd,
    input  logic [DIV_W-1:0] bit_div,
    output logic             sof,
    output logic             busy,
    output logic             byte_vld,
    output rx_byte_t         byte_out
);

    uart_state_e      st_q;
    logic [1:0]       sync_q;
    logic [DIV_W-1:0] cnt_q;
    logic [2:0]       nbit_q;
    logic [7:0]       sh_q;
    logic             ferr_q;
    logic             vld_q;
    logic             rx_s;

    assign rx_s     = sync_q[1];
    assign sof      = (st_q == U_IDLE) && !rx_s;
    assign busy     = (st_q != U_IDLE);
    assign byte_vld = vld_q;
    assign byte_out = '{data: sh_q, frame_err: ferr_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= U_IDLE;
            sync_q <= 2'b11;
            cnt_q  <= '0;
            nbit_q <= '0;
            sh_q   <= '0;
            ferr_q <= 1'b0;
            vld_q  <= 1'b0;
        end else begin
            vld_q  <= 1'b0;
            sync_q <= {sync_q[0], rxd};
            case (st_q)
                U_IDLE: begin
                    if (!rx_s) begin
                        st_q  <= U_START;
                        cnt_q <= '0;
                    end
                end
                U_START: begin
                    if (cnt_q == (bit_div >> 1)) begin
                        cnt_q  <= '0;
                        nbit_q <= '0;
                        st_q   <= rx_s ? U_IDLE : U_DATA;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                U_DATA: begin
                    if (cnt_q == bit_div - 1'b1) begin
                        cnt_q <= '0;
                        sh_q  <= {rx_s, sh_q[7:1]};
                        if (nbit_q == 3'd7) st_q <= U_STOP;
                        else                nbit_q <= nbit_q + 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (cnt_q == bit_div - 1'b1) begin
                        cnt_q  <= '0;
                        vld_q  <= 1'b1;
                        ferr_q <= !rx_s;
                        st_q   <= U_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/mbrx_crc_track.sv
module mbrx_crc_track
    import mbrx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc_before_tail,
    output logic [15:0] tail
);

    // Keep the running CRC and its values one and two bytes back, so that
    // the CRC over all bytes except the last two is always at hand.
    logic [15:0] crc_q [3];
    logic [15:0] tail_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < 3; i++) crc_q[i] <= 16'hFFFF;
            tail_q <= '0;
        end else if (en) begin
            crc_q[0] <= crc16_step(crc_q[0], din);
            crc_q[1] <= crc_q[0];
            crc_q[2] <= crc_q[1];
            tail_q   <= {din, tail_q[15:8]};
        end
    end

    assign crc_before_tail = crc_q[2];
    assign tail            = tail_q;

endmodule

// File: rtl/mbrx_buffer.sv
module mbrx_buffer #(
    parameter  int DEPTH = 256,
    localparam int AW    = $clog2(DEPTH),
    localparam int RW    = AW - 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          re,
    input  logic [RW-1:0] raddr,
    output logic [15:0]   rdata
);

    localparam int ROWS = DEPTH / 2;

    logic [1:0][7:0] q;

    generate
        for (genvar g = 0; g < 2; g++) begin : g_bank
            logic [7:0] mem [ROWS];
            always_ff @(posedge clk) begin
                if (we && (waddr[0] == 1'(g))) mem[waddr[AW-1:1]] <= wdata;
                if (re) q[g] <= mem[raddr];
            end
        end
    endgenerate

    assign rdata = {q[1], q[0]};

endmodule

// File: rtl/mbrx_channel.sv
module mbrx_channel
    import mbrx_pkg::*;
#(
    parameter int CH_W      = 4,
    parameter int CHAN_ID   = 0,
    parameter int DEPTH     = 256,
    parameter int DIV_W     = 16,
    parameter int RESP_W    = 24,
    parameter int CHAR_BITS = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rxd,
    input  logic [DIV_W-1:0]         bit_div,
    input  logic [RESP_W-1:0]        resp_ticks,
    input  logic                     arm,
    input  logic [CH_W+WIN_BITS-1:0] bus_addr,
    input  logic                     bus_rd,
    input  logic                     bus_wr,
    input  logic [15:0]              bus_wdata,
    output logic [15:0]              bus_rdata,
    output logic                     irq
);

    localparam int ADDR_W  = CH_W + WIN_BITS;
    localparam int BYTE_AW = $clog2(DEPTH);
    localparam int LEN_W   = BYTE_AW + 1;
    localparam int SIL_W   = DIV_W + 8;
    localparam int EOF_X2  = 7 * CHAR_BITS;

    rx_state_e         state_q, state_d;
    status_e           status_q;
    logic              irq_q;
    logic              armed_q;
    logic [RESP_W-1:0] resp_cnt_q;
    logic [SIL_W-1:0]  sil_cnt_q;
    logic [SIL_W-1:0]  eof_limit;
    logic [LEN_W-1:0]  len_q;
    logic              ovf_q, ferr_q;

    logic              sof, busy, byte_vld;
    rx_byte_t          rx_byte;
    logic [15:0]       crc_before_tail, tail;
    logic              frame_good, room, store;

    logic              hit, stat_rd, stat_wr, buf_re;
    logic [7:0]        off;
    logic [15:0]       buf_q;
    logic              rd_buf_q;
    logic [15:0]       rd_reg_q;

    mbrx_uart_rx #(.DIV_W(DIV_W)) u_rx (
        .clk(clk), .rst(rst), .rxd(rxd), .bit_div(bit_div),
        .sof(sof), .busy(busy), .byte_vld(byte_vld), .byte_out(rx_byte)
    );

    assign room  = (len_q < LEN_W'(DEPTH));
    assign store = (state_q == RX_GET_BYTE) && room;

    mbrx_crc_track u_crc (
        .clk(clk), .rst(rst),
        .clr((state_q == RX_IDLE) && sof),
        .en(store), .din(rx_byte.data),
        .crc_before_tail(crc_before_tail), .tail(tail)
    );

    assign hit     = (bus_addr[ADDR_W-1:WIN_BITS] == CH_W'(CHAN_ID));
    assign off     = bus_addr[WIN_BITS-1:0];
    assign stat_rd = bus_rd && hit && (off == 8'(OFS_STATUS));
    assign stat_wr = bus_wr && hit && (off == 8'(OFS_STATUS));
    assign buf_re  = bus_rd && hit && !off[7];

    mbrx_buffer #(.DEPTH(DEPTH)) u_buf (
        .clk(clk), .we(store), .waddr(len_q[BYTE_AW-1:0]), .wdata(rx_byte.data),
        .re(buf_re), .raddr(off[BYTE_AW-2:0]), .rdata(buf_q)
    );

    assign eof_limit  = SIL_W'((SIL_W'(bit_div) * SIL_W'(EOF_X2)) >> 1);
    assign frame_good = (len_q >= LEN_W'(MIN_FRAME)) && !ovf_q && !ferr_q
                        && (crc_before_tail == tail);

    always_comb begin
        state_d = state_q;
        case (state_q)
            RX_IDLE: begin
                if (sof)                                   state_d = RX_GET_DATA;
                else if (armed_q && resp_cnt_q >= resp_ticks) state_d = RX_TIMEOUT;
            end
            RX_GET_DATA: begin
                if (byte_vld)                              state_d = RX_GET_BYTE;
                else if (!busy && sil_cnt_q >= eof_limit)  state_d = RX_FRAME_DONE;
            end
            RX_GET_BYTE:   state_d = RX_GET_DATA;
            RX_TIMEOUT:    state_d = RX_IDLE;
            RX_FRAME_DONE: state_d = RX_IDLE;
            default:       state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= RX_IDLE;
            status_q   <= ST_NONE;
            irq_q      <= 1'b0;
            armed_q    <= 1'b0;
            resp_cnt_q <= '0;
            sil_cnt_q  <= '0;
            len_q      <= '0;
            ovf_q      <= 1'b0;
            ferr_q     <= 1'b0;
            rd_buf_q   <= 1'b0;
            rd_reg_q   <= '0;
        end else begin
            state_q <= state_d;

            if (busy || state_q == RX_IDLE) sil_cnt_q <= '0;
            else                            sil_cnt_q <= sil_cnt_q + 1'b1;

            if (arm) begin
                armed_q    <= 1'b1;
                resp_cnt_q <= '0;
            end else if ((state_q == RX_IDLE && sof) || state_q == RX_TIMEOUT) begin
                armed_q <= 1'b0;
            end else if (armed_q && state_q == RX_IDLE) begin
                resp_cnt_q <= resp_cnt_q + 1'b1;
            end

            if (state_q == RX_IDLE && sof) begin
                len_q  <= '0;
                ovf_q  <= 1'b0;
                ferr_q <= 1'b0;
            end else if (state_q == RX_GET_BYTE) begin
                ferr_q <= ferr_q | rx_byte.frame_err;
                if (room) len_q <= len_q + 1'b1;
                else      ovf_q <= 1'b1;
            end

            // Hardware outcomes take priority over host writes and reads.
            if (state_q == RX_FRAME_DONE)     status_q <= frame_good ? ST_DONE : ST_ERROR;
            else if (state_q == RX_TIMEOUT)   status_q <= ST_TIMEOUT;
            else if (stat_wr && bus_wdata == 16'd1) status_q <= ST_ERROR;
            else if (stat_wr && bus_wdata == 16'd0) status_q <= ST_NONE;

            if (state_q == RX_FRAME_DONE || state_q == RX_TIMEOUT) irq_q <= 1'b1;
            else if (stat_rd)                                       irq_q <= 1'b0;

            if (bus_rd) begin
                rd_buf_q <= buf_re;
                if (!hit)                          rd_reg_q <= '0;
                else if (off == 8'(OFS_STATUS))    rd_reg_q <= 16'(status_q);
                else if (off == 8'(OFS_LENGTH))    rd_reg_q <= 16'(len_q);
                else                               rd_reg_q <= '0;
            end
        end
    end

    assign bus_rdata = rd_buf_q ? buf_q : rd_reg_q;
    assign irq       = irq_q;

endmodule

// File: rtl/mbrx_checker.sv
module mbrx_checker
    import mbrx_pkg::*;
#(
    parameter int LEN_W = 9,
    parameter int DEPTH = 256
) (
    input logic             clk,
    input logic             rst,
    input rx_state_e        state,
    input status_e          status,
    input logic             irq,
    input logic             stat_rd,
    input logic [LEN_W-1:0] len
);

    AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        state == RX_FRAME_DONE |=> irq); // R9

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
        irq && !stat_rd |=> irq); // R9

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        stat_rd && state != RX_FRAME_DONE && state != RX_TIMEOUT |=> !irq); // R9

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(state) == RX_FRAME_DONE || $past(state) == RX_TIMEOUT)); // R9

    AST_TIMEOUT_CODE: assert property (@(posedge clk) disable iff (rst)
        state == RX_TIMEOUT |=> status == ST_TIMEOUT); // R8

    AST_SHORT_ERROR: assert property (@(posedge clk) disable iff (rst)
        state == RX_FRAME_DONE && len < LEN_W'(MIN_FRAME) |=> status == ST_ERROR); // R5

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
        len <= LEN_W'(DEPTH)); // R6

endmodule

bind mbrx_channel mbrx_checker #(.LEN_W(LEN_W), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .state(state_q), .status(status_q),
    .irq(irq), .stat_rd(stat_rd), .len(len_q)
);

// File: tb/mbrx_channel_bench.sv
module mbrx_channel_bench;

    localparam int CLK_PERIOD = 10;
    localparam int BIT_DIV    = 8;
    localparam int RESP       = 2000;
    localparam int CHAN       = 3;
    localparam int STAT_ADR   = CHAN * 256 + 128;
    localparam int LEN_ADR    = CHAN * 256 + 129;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rxd = 1'b1;
    logic        arm = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int compared   = 0;
    int mismatched = 0;
    bit expect_evt = 0;
    bit saw_rise   = 0;
    bit irq_prev   = 0;
    bit done_flag  = 0;
    logic [7:0] frame_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mbrx_channel #(.CHAN_ID(CHAN)) u_mbrx_channel (
        .clk(clk), .rst(rst), .rxd(rxd), .bit_div(16'(BIT_DIV)),
        .resp_ticks(24'(RESP)), .arm(arm), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(string req, string what, int got, int exp);
        compared++;
        if (got != exp) begin
            mismatched++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Interrupt rises are only legal while the bench expects an outcome.
    always @(negedge clk) begin
        if (!rst) begin
            if (irq && !irq_prev) begin
                saw_rise = 1;
                if (!expect_evt) begin
                    compared++;
                    mismatched++;
                    $display("FAIL R9 unexpected irq rise: got 1 expected 0");
                end
            end
            irq_prev = irq;
        end
    end

    task automatic bus_read(input int adr, output int val);
        @(negedge clk);
        bus_addr = 12'(adr);
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        val    = int'(bus_rdata);
    endtask

    task automatic bus_write(input int adr, input int val);
        @(negedge clk);
        bus_addr  = 12'(adr);
        bus_wdata = 16'(val);
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic line_bits(input logic v, input int nbits);
        rxd = v;
        repeat (nbits * BIT_DIV) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit stop_ok);
        line_bits(1'b0, 1);
        for (int i = 0; i < 8; i++) line_bits(b[i], 1);
        line_bits(stop_ok, 1);
        if (!stop_ok) line_bits(1'b1, 1);
        rxd = 1'b1;
    endtask

    function automatic int crc_calc();
        int c = 'hFFFF;
        foreach (frame_q[i]) begin
            c = c ^ int'(frame_q[i]);
            for (int k = 0; k < 8; k++) c = (c & 1) ? ((c >> 1) ^ 'hA001) : (c >> 1);
        end
        return c;
    endfunction

    task automatic add_crc();
        int c = crc_calc();
        frame_q.push_back(8'(c & 255));
        frame_q.push_back(8'(c >> 8));
    endtask

    task automatic send_frame(input int gap_after, input int bad_stop_at);
        foreach (frame_q[i]) begin
            send_byte(frame_q[i], i != bad_stop_at);
            if (i == gap_after) line_bits(1'b1, 20);
        end
    endtask

    task automatic wait_irq(input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (irq) break;
        end
    endtask

    task automatic expect_outcome(string req, int code, int len);
        int v;
        wait_irq(1500);
        check(req, "irq at outcome", int'(irq), 1);
        bus_read(STAT_ADR, v);
        check(req, "status code", v, code);
        if (len >= 0) begin
            bus_read(LEN_ADR, v);
            check(req, "frame length", v, len);
        end
        check("R9", "irq after status read", int'(irq), 0);
        expect_evt = 0;
    endtask

    task automatic check_buffer(string req);
        int v;
        for (int k = 0; k < (frame_q.size() + 1) / 2; k++) begin
            int exp = int'(frame_q[2*k]);
            if (2*k + 1 < frame_q.size()) exp = exp | (int'(frame_q[2*k+1]) << 8);
            bus_read(CHAN * 256 + k, v);
            if (2*k + 1 >= frame_q.size()) v = v & 255;
            check(req, $sformatf("buffer word %0d", k), v, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (200000 - 1000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        check("R12", "irq after reset", int'(irq), 0);
        check("R12", "rdata after reset", int'(bus_rdata), 0);
        bus_read(STAT_ADR, v);
        check("R12", "status after reset", v, 0);

        // R1 R3 good frame and buffer readback
        frame_q = '{8'h11, 8'h03, 8'h00, 8'h6B, 8'h00, 8'h03};
        add_crc();
        expect_evt = 1;
        send_frame(-1, -1);
        expect_outcome("R3", 1, 8);
        check_buffer("R1");

        // R2 short gap inside a frame keeps one frame
        frame_q = '{8'h01, 8'h04, 8'hA5, 8'h5A, 8'h10, 8'hFF};
        add_crc();
        expect_evt = 1;
        send_frame(2, -1);
        expect_outcome("R2", 1, 8);
        check_buffer("R2");

        // R4 corrupted CRC byte
        frame_q = '{8'h07, 8'h06, 8'h00, 8'h01, 8'h12, 8'h34};
        add_crc();
        frame_q[7] = frame_q[7] ^ 8'h01;
        expect_evt = 1;
        send_frame(-1, -1);
        expect_outcome("R4", 3, 8);

        // R5 three-byte frame, then a minimal good four-byte frame
        frame_q = '{8'h02};
        add_crc();
        expect_evt = 1;
        send_frame(-1, -1);
        expect_outcome("R5", 3, 3);
        frame_q = '{8'h02, 8'h81};
        add_crc();
        expect_evt = 1;
        send_frame(-1, -1);
        expect_outcome("R5", 1, 4);

        // R7 stop bit low in one byte
        frame_q = '{8'h09, 8'h03, 8'h00, 8'h02};
        add_crc();
        expect_evt = 1;
        send_frame(-1, 1);
        expect_outcome("R7", 3, 6);

        // R6 overflow past DEPTH bytes
        frame_q = {};
        for (int i = 0; i < 258; i++) frame_q.push_back(8'((i * 37 + 5) & 255));
        expect_evt = 1;
        send_frame(-1, -1);
        expect_outcome("R6", 3, 256);

        // R8 timeout with no response
        @(negedge clk);
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        expect_evt = 1;
        repeat (RESP - 100) @(negedge clk);
        check("R8", "irq before response window ends", int'(irq), 0);
        wait_irq(300);
        check("R8", "irq after response window", int'(irq), 1);
        bus_read(STAT_ADR, v);
        check("R8", "timeout status", v, 2);
        expect_evt = 0;

        // R8 armed, response arrives in time: no timeout
        @(negedge clk);
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        repeat (500) @(negedge clk);
        frame_q = '{8'h05, 8'h01, 8'h02};
        add_crc();
        expect_evt = 1;
        send_frame(-1, -1);
        expect_outcome("R8", 1, 5);
        repeat (3000) @(negedge clk);
        check("R8", "irq long after answered arm", int'(irq), 0);
        bus_read(STAT_ADR, v);
        check("R8", "status kept after answered arm", v, 1);

        // R10 force and clear of the error code
        bus_write(STAT_ADR, 1);
        bus_read(STAT_ADR, v);
        check("R10", "status after writing 1", v, 3);
        check("R10", "irq after writing 1", int'(irq), 0);
        bus_write(STAT_ADR, 5);
        bus_read(STAT_ADR, v);
        check("R10", "status after writing 5", v, 3);
        bus_write(STAT_ADR, 0);
        bus_read(STAT_ADR, v);
        check("R10", "status after writing 0", v, 0);

        // R11 other windows are ignored
        bus_write((CHAN + 1) * 256 + 128, 1);
        bus_read(STAT_ADR, v);
        check("R11", "own status after foreign write", v, 0);
        bus_read((CHAN + 1) * 256 + 129, v);
        check("R11", "foreign window read", v, 0);

        // R9 status read in the same cycle as frame completion
        frame_q = '{8'h21, 8'h03, 8'h00, 8'h10};
        add_crc();
        expect_evt = 1;
        saw_rise   = 0;
        send_frame(-1, -1);
        @(negedge clk);
        bus_addr = 12'(STAT_ADR);
        bus_rd   = 1'b1;
        v = 0;
        for (int i = 0; i < 1500; i++) begin
            @(negedge clk);
            v = int'(bus_rdata);
            if (v == 1) break;
        end
        bus_rd = 1'b0;
        @(negedge clk);
        check("R9", "status seen by back-to-back reads", v, 1);
        check("R9", "irq seen despite colliding read", int'(saw_rise), 1);
        check("R9", "irq after colliding reads", int'(irq), 0);
        expect_evt = 0;

        finish_run();
    end

endmodule